// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets the cores of a small cluster interrupt one another. A core issues a command through a shared command port. The command carries a two-bit code, a core-number parameter and the number of the issuing core. The unit keeps a matrix of pending bits indexed by receiver and sender, and drives one interrupt line per core.

A receiving core learns who interrupted it by asking for a multi-hot mask of senders. It then acknowledges each sender one at a time. Interrupts from several senders to one receiver share that receiver's single line. A core cannot interrupt itself through this unit.

Results come back in a registered readback word one cycle after the command. The core count is a parameter from 2 to 8.

Top module: `xcore_irq_hub`

## Requirements
- R1: After reset every pending bit is clear, every `irq_out` bit is low and `rdata` is zero.
- R2: A raise command (code 2'b01) from issuer `src_core` to target `cmd_core` sets that pending bit, and `irq_out[cmd_core]` is high in the cycle after the command.
- R3: A raise command whose target equals the issuer changes no pending bit and no `irq_out` bit.
- R4: A status command (code 2'b00) loads `rdata` with bit 0 = 1 when target `cmd_core` has any sender pending, and all other bits 0.
- R5: A source query (code 2'b10) loads `rdata` with a mask of the senders pending at the issuer, bit i standing for core i. Several bits may be set.
- R6: An acknowledge (code 2'b11) from receiver `src_core` naming sender `cmd_core` clears only that one pending bit. An acknowledge for a bit that is not pending changes nothing.
- R7: `irq_out[r]` is the OR of all senders pending at r. It falls in the cycle after the last of them is acknowledged.
- R8: Raise and acknowledge commands load `rdata` with zero. In a cycle without `cmd_valid`, `rdata` and all pending state hold.
- R9: A raise to a receiver that already has that sender pending leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_code | input | 2 | 00 status, 01 raise, 10 source query, 11 acknowledge |
| cmd_core | input | IDW | Core-number parameter of the command |
| src_core | input | IDW | Number of the core issuing the command |
| rdata | output | N | Registered readback result |
| irq_out | output | N | One interrupt line per core |

## Verification
The hardest situation to reach is a receiver holding several senders at once, then being acknowledged down to one and finally to none. Only in that state does merging on one line differ from a single-bit scheme. The bench raises every ordered sender/receiver pair, so each receiver's column fills up completely. It then acknowledges senders in ascending order, including the receiver's own number, which is never pending. After each step it checks the source mask and the line, so the partly drained masks and the exact cycle of the line's fall are all observed.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    typedef enum logic [1:0] {
        CMD_STATUS = 2'b00,
        CMD_RAISE  = 2'b01,
        CMD_WHO    = 2'b10,
        CMD_ACK    = 2'b11
    } xirq_cmd_e;
endpackage

// File: rtl/xirq_decode.sv
module xirq_decode #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic                    valid_i,
    input  logic [1:0]              code_i,
    input  logic [IDW-1:0]          core_i,
    input  logic [IDW-1:0]          issuer_i,
    output logic [N-1:0][N-1:0]     set_o,
    output logic [N-1:0][N-1:0]     clr_o,
    output logic                    rd_status_o,
    output logic                    rd_who_o,
    output logic                    rd_zero_o
);
    import xirq_pkg::*;

    localparam bit FULL = (N == (1 << IDW));

    logic      args_ok;
    xirq_cmd_e code;

    generate
        if (FULL) begin : g_full
            assign args_ok = 1'b1;
        end else begin : g_part
            assign args_ok = (core_i < IDW'(N)) && (issuer_i < IDW'(N));
        end
    endgenerate

    assign code = xirq_cmd_e'(code_i);

    always_comb begin
        set_o       = '0;
        clr_o       = '0;
        rd_status_o = 1'b0;
        rd_who_o    = 1'b0;
        rd_zero_o   = 1'b0;
        if (valid_i) begin
            rd_status_o = args_ok && (code == CMD_STATUS);
            rd_who_o    = args_ok && (code == CMD_WHO);
            rd_zero_o   = !(rd_status_o || rd_who_o);
            for (int r = 0; r < N; r++) begin
                for (int s = 0; s < N; s++) begin
                    if (args_ok && code == CMD_RAISE && r == int'(core_i)
                        && s == int'(issuer_i) && r != s)
                        set_o[r][s] = 1'b1;
                    if (args_ok && code == CMD_ACK && r == int'(issuer_i)
                        && s == int'(core_i))
                        clr_o[r][s] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xirq_pend_matrix.sv
module xirq_pend_matrix #(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0][N-1:0] set_i,
    input  logic [N-1:0][N-1:0] clr_i,
    output logic [N-1:0][N-1:0] pend_o,
    output logic [N-1:0]        line_o
);
    typedef struct packed {
        logic [N-1:0][N-1:0] col;
    } mat_t;

    mat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < N; r++)
            st_d.col[r] = (st_q.col[r] | set_i[r]) & ~clr_i[r];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.col;

    generate
        for (genvar r = 0; r < N; r++) begin : g_line
            assign line_o[r] = |st_q.col[r];
        end
    endgenerate
endmodule

// File: rtl/xirq_readback.sv
module xirq_readback #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0][N-1:0] pend_i,
    input  logic [N-1:0]        line_i,
    input  logic [IDW-1:0]      core_i,
    input  logic [IDW-1:0]      issuer_i,
    input  logic                rd_status_i,
    input  logic                rd_who_i,
    input  logic                rd_zero_i,
    output logic [N-1:0]        rdata_o
);
    typedef struct packed {
        logic [N-1:0] word;
    } rb_t;

    rb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_status_i) begin
            st_d.word    = '0;
            st_d.word[0] = line_i[core_i];
        end else if (rd_who_i) begin
            st_d.word = pend_i[issuer_i];
        end else if (rd_zero_i) begin
            st_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.word;
endmodule

// File: rtl/xcore_irq_hub.sv
module xcore_irq_hub #(
    parameter int N   = 4,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_code,
    input  logic [IDW-1:0] cmd_core,
    input  logic [IDW-1:0] src_core,
    output logic [N-1:0]   rdata,
    output logic [N-1:0]   irq_out
);
    logic [N-1:0][N-1:0] set_m, clr_m, pend;
    logic                rd_status, rd_who, rd_zero;

    xirq_decode #(.N(N), .IDW(IDW)) u_dec (
        .valid_i     (cmd_valid),
        .code_i      (cmd_code),
        .core_i      (cmd_core),
        .issuer_i    (src_core),
        .set_o       (set_m),
        .clr_o       (clr_m),
        .rd_status_o (rd_status),
        .rd_who_o    (rd_who),
        .rd_zero_o   (rd_zero)
    );

    xirq_pend_matrix #(.N(N)) u_mat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_m),
        .clr_i  (clr_m),
        .pend_o (pend),
        .line_o (irq_out)
    );

    xirq_readback #(.N(N), .IDW(IDW)) u_rb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .line_i      (irq_out),
        .core_i      (cmd_core),
        .issuer_i    (src_core),
        .rd_status_i (rd_status),
        .rd_who_i    (rd_who),
        .rd_zero_i   (rd_zero),
        .rdata_o     (rdata)
    );
endmodule

// File: rtl/xirq_hub_checker.sv
module xirq_hub_checker #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic [1:0]     cmd_code,
    input logic [IDW-1:0] cmd_core,
    input logic [IDW-1:0] src_core,
    input logic [N-1:0]   rdata,
    input logic [N-1:0]   irq_out
);
    // Reset leaves lines and readback cleared (R1)
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0) && (rdata == '0));

    p_raise_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 2'b01 && cmd_core != src_core
        |=> ((irq_out >> $past(cmd_core)) & N'(1)) != '0);

    p_self_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 2'b01 && cmd_core == src_core
        |=> $stable(irq_out));

    p_status_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 2'b00
        |=> rdata == N'(($past(irq_out) >> $past(cmd_core)) & N'(1)));

    p_who_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 2'b10
        |=> (rdata != '0) == ((($past(irq_out) >> $past(src_core)) & N'(1)) != '0));

    p_ack_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 2'b11
        |=> (irq_out & ~$past(irq_out)) == '0);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(irq_out) && $stable(rdata));

    p_write_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code[0] |=> rdata == '0);
endmodule

bind xcore_irq_hub xirq_hub_checker #(.N(N), .IDW(IDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_core  (cmd_core),
    .src_core  (src_core),
    .rdata     (rdata),
    .irq_out   (irq_out)
);

// File: tb/xcore_irq_hub_test.sv
module xcore_irq_hub_test;
    localparam int N   = 4;
    localparam int IDW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_code = 2'b00;
    logic [IDW-1:0] cmd_core = '0;
    logic [IDW-1:0] src_core = '0;
    logic [N-1:0]   rdata;
    logic [N-1:0]   irq_out;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] model [N];

    always #5 clk = ~clk;

    xcore_irq_hub #(.N(N), .IDW(IDW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_core(cmd_core), .src_core(src_core), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [N-1:0] lines_exp();
        logic [N-1:0] v;
        for (int r = 0; r < N; r++) v[r] = |model[r];
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, capture at the rising edge, sample at the next falling edge
    task automatic issue(input logic [1:0] code, input int core, input int src);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_core  = IDW'(core);
        src_core  = IDW'(src);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", i_dummy());
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int i_dummy(); return 0; endfunction

    initial begin
        logic [N-1:0] hold;
        for (int r = 0; r < N; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lines", irq_out, '0);
        check("R1 rdata", rdata, '0);

        // self raise for every core
        for (int c = 0; c < N; c++) begin
            issue(2'b01, c, c);
            check("R3 self raise lines", irq_out, '0);
            check("R8 raise readback", rdata, '0);
        end

        // raise every ordered pair
        for (int s = 0; s < N; s++) begin
            for (int r = 0; r < N; r++) begin
                if (r == s) continue;
                issue(2'b01, r, s);
                model[r][s] = 1'b1;
                check("R2 raise line", irq_out, lines_exp());
                check("R8 raise readback", rdata, '0);
                issue(2'b01, r, s);
                check("R9 duplicate raise", irq_out, lines_exp());
                for (int t = 0; t < N; t++) begin
                    issue(2'b00, t, s);
                    check("R4 status", rdata, {{(N-1){1'b0}}, |model[t]});
                end
                for (int q = 0; q < N; q++) begin
                    issue(2'b10, (q + 1) % N, q);
                    check("R5 source mask", rdata, model[q]);
                end
            end
        end

        // idle hold
        hold = rdata;
        repeat (4) @(negedge clk);
        check("R8 idle readback", rdata, hold);
        check("R8 idle lines", irq_out, lines_exp());

        // drain each receiver one sender at a time
        for (int r = 0; r < N; r++) begin
            for (int s = 0; s < N; s++) begin
                issue(2'b11, s, r);
                model[r][s] = 1'b0;
                check("R6 ack lines", irq_out, lines_exp());
                check("R8 ack readback", rdata, '0);
                issue(2'b10, 0, r);
                check("R6 remaining mask", rdata, model[r]);
                check("R7 merged line", irq_out[r], |model[r]);
            end
        end

        // acknowledge of a sender that is not pending is ignored
        issue(2'b01, 1, 2);
        model[1][2] = 1'b1;
        issue(2'b11, 0, 1);
        check("R6 stray ack line", irq_out, lines_exp());
        issue(2'b10, 3, 1);
        check("R6 stray ack mask", rdata, 4'b0100);
        issue(2'b11, 2, 1);
        model[1][2] = 1'b0;
        check("R7 line falls", irq_out, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule